// File: doc/BRIEF.md
# ADC Sampling Phase Trigger Controller

This block decides when an ADC front end samples its input and when the conversion begins. It has an external trigger, a software start request and a software gate bit as inputs, and it watches the converter's end-of-conversion pulse. It drives a level that holds the sample switch closed and a one-clock pulse that starts the conversion.

There are three operating modes. In timed mode the sampling window lasts a programmed number of clocks. In gated mode the window follows a trigger pulse: it opens on a rising edge and the conversion starts on the falling edge. The trigger is either the external pin or the software gate bit. In follow mode, after the first timed conversion, sampling resumes as soon as each conversion ends, and the next trigger starts a conversion at once. If the mode bits ask for a combination that cannot work, the block flags a configuration error and stays idle. Mode bits are changed only while the block is idle.

Top module: `adc_sample_ctrl`

## Requirements
- R1: After reset, `sampling` and `conv_start` are both 0.
- R2: The external trigger passes through two synchronizer flops and an edge register. A level change applied before clock edge k takes effect at edge k+2, so the outputs change after edge k+2 and not earlier.
- R3: Timed mode applies when `gate_en`=0 and `follow_en`=0. A start event is one of the following: an external edge chosen by `edge_sel` (01 rising, 10 falling, 11 both), or, when `edge_sel`=00, a `sw_start` pulse with `sw_gate`=1. A start event raises `sampling` for max(`smp_cycles`,1) clocks. `conv_start` then pulses while `sampling` is low.
- R4: In timed mode with `edge_sel`=00 and `sw_gate`=0, a `sw_start` pulse at edge k gives `conv_start`=1 after edge k, and `sampling` stays 0.
- R5: Gated mode with `edge_sel`=01: `sampling` rises after the synchronized rising trigger edge and stays high while the trigger is high. After the synchronized falling edge, `sampling` drops and `conv_start` pulses in the same cycle.
- R6: Gated mode with `edge_sel`=00: a 0→1 change of `sw_gate` before edge k raises `sampling` after edge k. A 1→0 change before edge k gives `conv_start`=1 and `sampling`=0 after edge k.
- R7: In follow mode (`follow_en`=1, `gate_en`=0), the first start event gives a timed window as in R3. An `eoc` during a conversion raises `sampling` on the next clock. The next start event then pulses `conv_start` on the next clock, with no timed window. Clearing `follow_en` while the block waits for that event returns it to idle.
- R8: `cfg_err` is 1 whenever `gate_en` and `follow_en` are both 1, or whenever `gate_en`=1 with `edge_sel` of 10 or 11. While it is set, the block goes idle and gives neither `sampling` nor `conv_start`.
- R9: `conv_start` is never high for two consecutive clocks and is never high together with `sampling`.
- R10: Once `conv_start` has pulsed, further triggers are ignored until `eoc`. An `eoc` outside follow mode returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | External trigger level, asynchronous |
| edge_sel | input | 2 | Trigger source/edge: 00 software, 01 rising, 10 falling, 11 both |
| sw_start | input | 1 | Software start request, one-clock pulse |
| sw_gate | input | 1 | Software gate bit |
| gate_en | input | 1 | Gated sampling mode enable |
| follow_en | input | 1 | Follow (sample after end of conversion) mode enable |
| smp_cycles | input | SMP_W | Programmed sampling time in clocks |
| eoc | input | 1 | End-of-conversion pulse from the converter |
| sampling | output | 1 | Sampling window active |
| conv_start | output | 1 | One-clock conversion start pulse |
| cfg_err | output | 1 | Invalid mode combination |

## Verification
A wrong internal state shows up on `sampling` within one clock. It appears as a window that opens or closes too early, stays open, or fails to open after an end of conversion. A counter or synchronizer that is off by one moves the edges of `sampling` and `conv_start` by whole clocks, so the bench samples each edge in the exact cycle that the pipeline count predicts. A state machine stuck in conversion shows as a missing `conv_start` on the next trigger. A stray pulse during a conversion, or under a configuration error, is visible on `conv_start` in the same cycle.

// File: rtl/adc_samp_pkg.sv
package adc_samp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_TIMED  = 3'd1,
    ST_GATED  = 3'd2,
    ST_FOLLOW = 3'd3,
    ST_CONV   = 3'd4
  } samp_state_e;

  localparam logic [1:0] EDGE_SW   = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_FALL = 2'b10;
  localparam logic [1:0] EDGE_BOTH = 2'b11;

endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              last_q;

  assign chain_d[0] = trig_in;

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      assign chain_d[g] = chain_q[g-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise = chain_q[STAGES-1] & ~last_q;
  assign fall = ~chain_q[STAGES-1] & last_q;

endmodule

// File: rtl/adc_trig_event.sv
module adc_trig_event
  import adc_samp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] edge_sel,
  input  logic       ext_rise,
  input  logic       ext_fall,
  input  logic       sw_start,
  input  logic       sw_gate,
  output logic       start_evt,
  output logic       open_evt,
  output logic       close_evt
);

  logic sw_gate_q;
  logic sw_rise;
  logic sw_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_gate_q <= 1'b0;
    else        sw_gate_q <= sw_gate;
  end

  assign sw_rise = sw_gate & ~sw_gate_q;
  assign sw_fall = ~sw_gate & sw_gate_q;

  always_comb begin
    unique case (edge_sel)
      EDGE_SW:   start_evt = sw_start;
      EDGE_RISE: start_evt = ext_rise;
      EDGE_FALL: start_evt = ext_fall;
      default:   start_evt = ext_rise | ext_fall;
    endcase
    open_evt  = (edge_sel == EDGE_SW) ? sw_rise : ext_rise;
    close_evt = (edge_sel == EDGE_SW) ? sw_fall : ext_fall;
  end

endmodule

// File: rtl/adc_samp_timer.sv
module adc_samp_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         expired
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_d  = load ? load_val : (cnt_q - W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q <= W'(1));

endmodule

// File: rtl/adc_sample_ctrl.sv
module adc_sample_ctrl
  import adc_samp_pkg::*;
#(
  parameter int SMP_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_in,
  input  logic [1:0]       edge_sel,
  input  logic             sw_start,
  input  logic             sw_gate,
  input  logic             gate_en,
  input  logic             follow_en,
  input  logic [SMP_W-1:0] smp_cycles,
  input  logic             eoc,
  output logic             sampling,
  output logic             conv_start,
  output logic             cfg_err
);

  samp_state_e state_q, state_d;
  logic        conv_q, conv_d;
  logic        ext_rise, ext_fall;
  logic        start_evt, open_evt, close_evt;
  logic        tmr_load, tmr_dec, tmr_expired;
  logic        direct_conv;

  adc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_in (trig_in),
    .rise    (ext_rise),
    .fall    (ext_fall)
  );

  adc_trig_event u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_sel  (edge_sel),
    .ext_rise  (ext_rise),
    .ext_fall  (ext_fall),
    .sw_start  (sw_start),
    .sw_gate   (sw_gate),
    .start_evt (start_evt),
    .open_evt  (open_evt),
    .close_evt (close_evt)
  );

  adc_samp_timer #(.W(SMP_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (smp_cycles),
    .dec      (tmr_dec),
    .expired  (tmr_expired)
  );

  assign cfg_err     = (gate_en & follow_en) | (gate_en & edge_sel[1]);
  assign direct_conv = (edge_sel == EDGE_SW) & ~sw_gate & ~follow_en;

  always_comb begin
    state_d  = state_q;
    conv_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_dec  = 1'b0;
    if (cfg_err) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (gate_en) begin
            if (open_evt) state_d = ST_GATED;
          end else if (start_evt) begin
            if (direct_conv) begin
              conv_d  = 1'b1;
              state_d = ST_CONV;
            end else begin
              tmr_load = 1'b1;
              state_d  = ST_TIMED;
            end
          end
        end
        ST_TIMED: begin
          tmr_dec = 1'b1;
          if (tmr_expired) begin
            conv_d  = 1'b1;
            state_d = ST_CONV;
          end
        end
        ST_GATED: begin
          if (!gate_en) begin
            state_d = ST_IDLE;
          end else if (close_evt) begin
            conv_d  = 1'b1;
            state_d = ST_CONV;
          end
        end
        ST_FOLLOW: begin
          if (!follow_en) begin
            state_d = ST_IDLE;
          end else if (start_evt) begin
            conv_d  = 1'b1;
            state_d = ST_CONV;
          end
        end
        ST_CONV: begin
          if (eoc) state_d = follow_en ? ST_FOLLOW : ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      conv_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      conv_q  <= conv_d;
    end
  end

  assign sampling   = (state_q == ST_TIMED) | (state_q == ST_GATED) |
                      (state_q == ST_FOLLOW);
  assign conv_start = conv_q;

endmodule

// File: rtl/adc_sample_ctrl_chk.sv
module adc_sample_ctrl_chk
  import adc_samp_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        follow_en,
  input logic        eoc,
  input logic        sampling,
  input logic        conv_start,
  input logic        cfg_err,
  input samp_state_e state_q
);

  p_conv_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  p_conv_not_sampling_r9: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !sampling);

  p_err_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> (!sampling && !conv_start));

  p_follow_after_eoc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONV && follow_en && !cfg_err && eoc) |=> sampling);

  p_conv_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONV && !eoc && !cfg_err) |=> (!conv_start && !sampling));

endmodule

bind adc_sample_ctrl adc_sample_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .follow_en  (follow_en),
  .eoc        (eoc),
  .sampling   (sampling),
  .conv_start (conv_start),
  .cfg_err    (cfg_err),
  .state_q    (state_q)
);

// File: tb/tb_adc_sample_ctrl.sv
module tb_adc_sample_ctrl;

  localparam int SMP_W = 10;

  logic             clk;
  logic             rst_n;
  logic             trig_in;
  logic [1:0]       edge_sel;
  logic             sw_start;
  logic             sw_gate;
  logic             gate_en;
  logic             follow_en;
  logic [SMP_W-1:0] smp_cycles;
  logic             eoc;
  logic             sampling;
  logic             conv_start;
  logic             cfg_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  adc_sample_ctrl #(.SMP_W(SMP_W)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_in    (trig_in),
    .edge_sel   (edge_sel),
    .sw_start   (sw_start),
    .sw_gate    (sw_gate),
    .gate_en    (gate_en),
    .follow_en  (follow_en),
    .smp_cycles (smp_cycles),
    .eoc        (eoc),
    .sampling   (sampling),
    .conv_start (conv_start),
    .cfg_err    (cfg_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic outs(input logic s, input logic c, input string tag);
    chk({31'd0, sampling}, {31'd0, s}, {tag, " sampling"});
    chk({31'd0, conv_start}, {31'd0, c}, {tag, " conv_start"});
  endtask

  task automatic pulse_sw_start();
    sw_start = 1'b1; step(1); sw_start = 1'b0;
  endtask

  task automatic pulse_eoc();
    eoc = 1'b1; step(1); eoc = 1'b0;
  endtask

  task automatic t_reset_r1();
    outs(1'b0, 1'b0, "R1 reset");
    chk({31'd0, cfg_err}, 32'd0, "R1 cfg_err");
  endtask

  task automatic t_sync_timed_r2_r3();
    edge_sel = 2'b01; smp_cycles = 10'd4; step(2);
    trig_in = 1'b1; step(2);
    outs(1'b0, 1'b0, "R2 before sync");
    step(1);
    outs(1'b1, 1'b0, "R2 after sync");
    step(3);
    outs(1'b1, 1'b0, "R3 window end");
    step(1);
    outs(1'b0, 1'b1, "R3 conv");
    step(1);
    outs(1'b0, 1'b0, "R9 pulse ends");
    trig_in = 1'b0; step(4);
    outs(1'b0, 1'b0, "R10 fall ignored");
    pulse_eoc();
    outs(1'b0, 1'b0, "R10 idle after eoc");
  endtask

  task automatic t_sw_min_r3();
    edge_sel = 2'b00; sw_gate = 1'b1; smp_cycles = 10'd0; step(2);
    pulse_sw_start();
    outs(1'b1, 1'b0, "R3 min window");
    step(1);
    outs(1'b0, 1'b1, "R3 min conv");
    pulse_eoc();
    sw_gate = 1'b0; step(2);
  endtask

  task automatic t_direct_r4_r10();
    edge_sel = 2'b00; sw_gate = 1'b0; step(1);
    pulse_sw_start();
    outs(1'b0, 1'b1, "R4 direct conv");
    step(1);
    pulse_sw_start();
    outs(1'b0, 1'b0, "R10 start ignored in conv");
    step(2);
    outs(1'b0, 1'b0, "R10 still waiting");
    pulse_eoc();
    pulse_sw_start();
    outs(1'b0, 1'b1, "R10 accepts after eoc");
    step(1);
    pulse_eoc();
  endtask

  task automatic t_gate_ext_r5();
    gate_en = 1'b1; edge_sel = 2'b01; step(2);
    trig_in = 1'b1; step(3);
    outs(1'b1, 1'b0, "R5 open");
    step(6);
    outs(1'b1, 1'b0, "R5 held");
    trig_in = 1'b0; step(2);
    outs(1'b1, 1'b0, "R5 before close");
    step(1);
    outs(1'b0, 1'b1, "R5 conv");
    step(1);
    pulse_eoc();
    outs(1'b0, 1'b0, "R5 idle");
  endtask

  task automatic t_gate_sw_r6();
    gate_en = 1'b1; edge_sel = 2'b00; sw_gate = 1'b0; step(2);
    sw_gate = 1'b1; step(1);
    outs(1'b1, 1'b0, "R6 open");
    step(3);
    outs(1'b1, 1'b0, "R6 held");
    sw_gate = 1'b0; step(1);
    outs(1'b0, 1'b1, "R6 conv");
    step(1);
    pulse_eoc();
    gate_en = 1'b0; step(1);
  endtask

  task automatic t_follow_r7();
    follow_en = 1'b1; edge_sel = 2'b00; sw_gate = 1'b0; smp_cycles = 10'd2; step(2);
    pulse_sw_start();
    outs(1'b1, 1'b0, "R7 first timed");
    step(1);
    outs(1'b1, 1'b0, "R7 first timed 2");
    step(1);
    outs(1'b0, 1'b1, "R7 first conv");
    step(2);
    pulse_eoc();
    outs(1'b1, 1'b0, "R7 sample after eoc");
    step(3);
    outs(1'b1, 1'b0, "R7 waits");
    pulse_sw_start();
    outs(1'b0, 1'b1, "R7 immediate conv");
    step(1);
    pulse_eoc();
    outs(1'b1, 1'b0, "R7 resample");
    follow_en = 1'b0; step(1);
    outs(1'b0, 1'b0, "R7 exit");
  endtask

  task automatic t_err_r8();
    gate_en = 1'b1; follow_en = 1'b1; edge_sel = 2'b00; step(1);
    chk({31'd0, cfg_err}, 32'd1, "R8 both modes");
    pulse_sw_start();
    sw_gate = 1'b1; step(2);
    outs(1'b0, 1'b0, "R8 idle");
    sw_gate = 1'b0; step(2);
    outs(1'b0, 1'b0, "R8 idle 2");
    follow_en = 1'b0; edge_sel = 2'b10; step(1);
    chk({31'd0, cfg_err}, 32'd1, "R8 gate falling code");
    trig_in = 1'b1; step(4);
    outs(1'b0, 1'b0, "R8 no sampling");
    trig_in = 1'b0; step(4);
    gate_en = 1'b0; edge_sel = 2'b00; step(1);
    chk({31'd0, cfg_err}, 32'd0, "R8 cleared");
  endtask

  initial begin
    rst_n = 1'b0; trig_in = 1'b0; edge_sel = 2'b00; sw_start = 1'b0;
    sw_gate = 1'b0; gate_en = 1'b0; follow_en = 1'b0; smp_cycles = '0; eoc = 1'b0;
    step(3);
    t_reset_r1();
    rst_n = 1'b1; step(2);
    t_reset_r1();
    t_sync_timed_r2_r3();
    t_sw_min_r3();
    t_direct_r4_r10();
    t_gate_ext_r5();
    t_gate_sw_r6();
    t_follow_r7();
    t_err_r8();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule